// File: doc/BRIEF.md
# Extended-Data-Out Page DRAM Controller

This block sits between a simple host port and a 4-bit-wide extended-data-out DRAM whose address lines are shared between the row and the column half of each access. The host presents one request at a time, a read or a write with a flat word address, and holds it until the block raises its ready signal. The block opens the addressed row by lowering the row strobe with the row half of the address on the bus. It then lowers the column strobe with the column half, and after that it leaves the row open, so later requests to the same row need only a new column pulse.

Read data is sampled while the column strobe is already back high. The device keeps its output valid in that phase as long as the row strobe and the output enable stay low. The controller owns the direction of the shared data pins. It drives them only during a write column pulse, and only after the output enable has been high for at least a cycle. It closes the open row on a row miss, after a run of idle cycles, and before a refresh. Refresh runs as column-before-row cycles paced by an interval counter. Every timing window is a whole number of clock cycles given as a parameter.

Top module: `edo_page_ctrl`

## Requirements
- R1: While reset is low, the row strobe, column strobe, write enable and output enable are all high, the data drivers are off and no read-valid pulse is given.
- R2: An activation lowers the row strobe with address bits [21:11] on the bus and holds them for exactly RCD_CYC cycles. The column strobe then falls with address bits [10:0] on the bus.
- R3: Each column strobe pulse during an access lasts exactly CAS_CYC cycles. Within an open row, the column strobe stays high for at least CP_CYC cycles between two pulses.
- R4: A request whose row field matches the open row is served with a new column pulse only, with no new activation.
- R5: The row strobe is high for at least RP_CYC cycles before any falling edge, whether it follows a row miss, an idle close or a refresh.
- R6: Every read returns the value last written to that address, or the device's stored value if never written. It comes back as a single-cycle rd_valid pulse, in the order the reads were accepted.
- R7: A write lowers the write enable and turns on the data drivers only while the column strobe is low and the output enable is high. The drivers are never on while the output enable is low, nor in the first cycle after it was low.
- R8: The output enable is low only with the write enable high and the row strobe low, and it is low at the falling column strobe of every read.
- R9: Refresh lowers the column strobe before the row strobe. Successive refreshes are between REF_INTERVAL and REF_INTERVAL+24 cycles apart, and a refresh that is due closes an open row first.
- R10: With no request pending, an open row is closed after the column strobe has stayed high for CP_CYC+IDLE_CYC cycles.
- R11: The host request is taken in the cycle where req_valid and req_ready are both high, and req_ready is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request taken this cycle if req_valid is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Word address, row field in upper bits |
| req_wdata | input | DQ_W | Write data |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | DQ_W | Read data |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | DQ_W | Data toward the device |
| dram_dq_oe | output | 1 | Drive enable of the shared data pins |
| dram_dq_in | input | DQ_W | Data from the device |

## Verification
The bench goes after the turnaround between a read and a write in the same open row. A controller that lowered the output enable too late, or turned its drivers on in the same cycle it raised it, would fight the device on the data pins or lose the write. It counts activations across same-row and alternating-row sequences, so a controller that reopens a row on every hit, or skips precharge on a miss, shows up as a wrong count or a short high phase of the row strobe. It also measures the idle-close window and the spacing between refresh cycles. A refresh that overlapped an open row, or one given column-after-row, would be flagged at the pins. Random traffic on rows including the all-ones row keeps the row/column split and the read order under check.

// File: rtl/edo_ctrl_pkg.sv
package edo_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,   // row closed and precharged
    ST_ACT,    // row strobe low, row address on bus
    ST_COL,    // column strobe low
    ST_CPRE,   // column strobe high again, read data sampled at its end
    ST_OPEN,   // row held open, waiting for a hit
    ST_PRE,    // row strobe high, precharge
    ST_REFC,   // refresh: column strobe low first
    ST_REFR    // refresh: row strobe follows
  } edo_state_e;

  typedef enum logic [1:0] {
    AS_NONE,
    AS_ROW,
    AS_COL
  } addr_sel_e;

  typedef struct packed {
    logic ras_n;
    logic cas_n;
    logic we_n;
    logic oe_n;
    logic drive;
  } edo_strobe_t;

  function automatic int cyc_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/edo_cycle_timer.sv
module edo_cycle_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/edo_refresh_timer.sv
module edo_refresh_timer #(
  parameter int INTERVAL = 780,
  localparam int REF_W = $clog2(INTERVAL + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack,
  output logic due
);

  localparam logic [REF_W-1:0] RELOAD = REF_W'(INTERVAL - 1);

  logic [REF_W-1:0] cnt_q;
  logic [REF_W-1:0] cnt_d;
  logic             pend_q;
  logic             pend_d;

  always_comb begin
    cnt_d  = cnt_q - 1'b1;
    pend_d = pend_q;
    if (ack) begin
      cnt_d  = RELOAD;
      pend_d = 1'b0;
    end else if (cnt_q == '0) begin
      cnt_d  = RELOAD;
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= RELOAD;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign due = pend_q;

endmodule

// File: rtl/edo_addr_mux.sv
module edo_addr_mux
  import edo_ctrl_pkg::*;
#(
  parameter int ROW_W = 11,
  parameter int COL_W = 11,
  localparam int ADDR_W = ROW_W + COL_W,
  localparam int BUS_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ROW_W-1:0]  row_q,
  input  logic [COL_W-1:0]  col_q,
  input  addr_sel_e         sel,
  output logic [ROW_W-1:0]  req_row,
  output logic [COL_W-1:0]  req_col,
  output logic              row_hit,
  output logic [BUS_W-1:0]  bus_addr
);

  logic [BUS_W-1:0] row_wide;
  logic [BUS_W-1:0] col_wide;

  assign req_row = req_addr[ADDR_W-1:COL_W];
  assign req_col = req_addr[COL_W-1:0];
  assign row_hit = (req_row == row_q);

  if (ROW_W == BUS_W) begin : g_row_full
    assign row_wide = row_q;
  end else begin : g_row_pad
    assign row_wide = {{(BUS_W-ROW_W){1'b0}}, row_q};
  end

  if (COL_W == BUS_W) begin : g_col_full
    assign col_wide = col_q;
  end else begin : g_col_pad
    assign col_wide = {{(BUS_W-COL_W){1'b0}}, col_q};
  end

  always_comb begin
    unique case (sel)
      AS_ROW:  bus_addr = row_wide;
      AS_COL:  bus_addr = col_wide;
      default: bus_addr = '0;
    endcase
  end

endmodule

// File: rtl/edo_page_ctrl.sv
module edo_page_ctrl
  import edo_ctrl_pkg::*;
#(
  parameter int ROW_W        = 11,
  parameter int COL_W        = 11,
  parameter int DQ_W         = 4,
  parameter int RCD_CYC      = 2,
  parameter int CAS_CYC      = 2,
  parameter int CP_CYC       = 1,
  parameter int RP_CYC       = 3,
  parameter int CSR_CYC      = 1,
  parameter int REFR_CYC     = 4,
  parameter int IDLE_CYC     = 8,
  parameter int REF_INTERVAL = 780,
  localparam int ADDR_W = ROW_W + COL_W,
  localparam int BUS_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DQ_W-1:0]   req_wdata,
  output logic              rd_valid,
  output logic [DQ_W-1:0]   rd_data,
  output logic [BUS_W-1:0]  dram_addr,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic              dram_oe_n,
  output logic [DQ_W-1:0]   dram_dq_out,
  output logic              dram_dq_oe,
  input  logic [DQ_W-1:0]   dram_dq_in
);

  localparam int MAX_CYC = cyc_max(cyc_max(cyc_max(RCD_CYC, CAS_CYC), cyc_max(CP_CYC, RP_CYC)),
                                   cyc_max(cyc_max(CSR_CYC, REFR_CYC), IDLE_CYC));
  localparam int CNT_W = $clog2(MAX_CYC + 1);

  localparam logic [CNT_W-1:0] LD_RCD  = CNT_W'(RCD_CYC - 1);
  localparam logic [CNT_W-1:0] LD_CAS  = CNT_W'(CAS_CYC - 1);
  localparam logic [CNT_W-1:0] LD_CP   = CNT_W'(CP_CYC - 1);
  localparam logic [CNT_W-1:0] LD_RP   = CNT_W'(RP_CYC - 1);
  localparam logic [CNT_W-1:0] LD_CSR  = CNT_W'(CSR_CYC - 1);
  localparam logic [CNT_W-1:0] LD_REFR = CNT_W'(REFR_CYC - 1);
  localparam logic [CNT_W-1:0] LD_IDLE = CNT_W'(IDLE_CYC - 1);

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_core_n = rst_pipe_q[1];

  edo_state_e        state_q;
  edo_state_e        state_d;
  logic              tmr_load;
  logic [CNT_W-1:0]  tmr_val;
  logic              tmr_done;
  logic              ref_due;
  logic              ref_ack;
  logic              accept;
  logic              capture;
  logic              row_hit;
  logic [ROW_W-1:0]  req_row;
  logic [COL_W-1:0]  req_col;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic              wr_q;
  logic [DQ_W-1:0]   wdata_q;
  logic [DQ_W-1:0]   rd_data_q;
  logic              rd_valid_q;
  addr_sel_e         addr_sel;
  edo_strobe_t       strb;

  edo_cycle_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  edo_refresh_timer #(
    .INTERVAL (REF_INTERVAL)
  ) u_refresh (
    .clk   (clk),
    .rst_n (rst_core_n),
    .ack   (ref_ack),
    .due   (ref_due)
  );

  edo_addr_mux #(
    .ROW_W (ROW_W),
    .COL_W (COL_W)
  ) u_addr (
    .req_addr (req_addr),
    .row_q    (row_q),
    .col_q    (col_q),
    .sel      (addr_sel),
    .req_row  (req_row),
    .req_col  (req_col),
    .row_hit  (row_hit),
    .bus_addr (dram_addr)
  );

  // host handshake: a new row only from the precharged state, a hit from the open row
  always_comb begin
    req_ready = 1'b0;
    if (!ref_due) begin
      if (state_q == ST_IDLE) begin
        req_ready = 1'b1;
      end else if (state_q == ST_OPEN) begin
        req_ready = row_hit;
      end
    end
  end

  // next-state process
  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    accept   = 1'b0;
    ref_ack  = 1'b0;
    capture  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (ref_due) begin
          state_d  = ST_REFC;
          tmr_load = 1'b1;
          tmr_val  = LD_CSR;
          ref_ack  = 1'b1;
        end else if (req_valid) begin
          accept   = 1'b1;
          state_d  = ST_ACT;
          tmr_load = 1'b1;
          tmr_val  = LD_RCD;
        end
      end
      ST_ACT: begin
        if (tmr_done) begin
          state_d  = ST_COL;
          tmr_load = 1'b1;
          tmr_val  = LD_CAS;
        end
      end
      ST_COL: begin
        if (tmr_done) begin
          state_d  = ST_CPRE;
          tmr_load = 1'b1;
          tmr_val  = LD_CP;
        end
      end
      ST_CPRE: begin
        if (tmr_done) begin
          capture  = !wr_q;
          state_d  = ST_OPEN;
          tmr_load = 1'b1;
          tmr_val  = LD_IDLE;
        end
      end
      ST_OPEN: begin
        if (ref_due || (req_valid && !row_hit) || (!req_valid && tmr_done)) begin
          state_d  = ST_PRE;
          tmr_load = 1'b1;
          tmr_val  = LD_RP;
        end else if (req_valid) begin
          accept   = 1'b1;
          state_d  = ST_COL;
          tmr_load = 1'b1;
          tmr_val  = LD_CAS;
        end
      end
      ST_PRE: begin
        if (tmr_done) begin
          state_d = ST_IDLE;
        end
      end
      ST_REFC: begin
        if (tmr_done) begin
          state_d  = ST_REFR;
          tmr_load = 1'b1;
          tmr_val  = LD_REFR;
        end
      end
      ST_REFR: begin
        if (tmr_done) begin
          state_d  = ST_PRE;
          tmr_load = 1'b1;
          tmr_val  = LD_RP;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // state register
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  // request latch, enabled on acceptance
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      wr_q    <= 1'b0;
      row_q   <= '0;
      col_q   <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      wr_q    <= req_write;
      row_q   <= req_row;
      col_q   <= req_col;
      wdata_q <= req_wdata;
    end
  end

  // read return, sampled at the end of the column precharge
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= capture;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      rd_data_q <= '0;
    end else if (capture) begin
      rd_data_q <= dram_dq_in;
    end
  end

  // pin decode from the current state
  always_comb begin
    strb     = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};
    addr_sel = AS_NONE;
    unique case (state_q)
      ST_ACT: begin
        strb.ras_n = 1'b0;
        addr_sel   = AS_ROW;
      end
      ST_COL: begin
        strb.ras_n = 1'b0;
        strb.cas_n = 1'b0;
        strb.we_n  = !wr_q;
        strb.oe_n  = wr_q;
        strb.drive = wr_q;
        addr_sel   = AS_COL;
      end
      ST_CPRE: begin
        strb.ras_n = 1'b0;
        strb.oe_n  = wr_q;
        addr_sel   = AS_COL;
      end
      ST_OPEN: begin
        strb.ras_n = 1'b0;
      end
      ST_REFC: begin
        strb.cas_n = 1'b0;
      end
      ST_REFR: begin
        strb.ras_n = 1'b0;
        strb.cas_n = 1'b0;
      end
      default: begin
        strb.ras_n = 1'b1;
      end
    endcase
  end

  assign dram_ras_n  = strb.ras_n;
  assign dram_cas_n  = strb.cas_n;
  assign dram_we_n   = strb.we_n;
  assign dram_oe_n   = strb.oe_n;
  assign dram_dq_oe  = strb.drive;
  assign dram_dq_out = wdata_q;
  assign rd_valid    = rd_valid_q;
  assign rd_data     = rd_data_q;

endmodule

// File: rtl/edo_page_ctrl_chk.sv
module edo_page_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic rd_valid,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic oe_n,
  input logic dq_oe
);

  // R1: strobes idle and drivers off while reset is held
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (ras_n && cas_n && we_n && oe_n && !dq_oe && !rd_valid));

  // R2: a column strobe in an access follows a row strobe already low
  p_row_before_col_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && !ras_n) |-> $past(!ras_n));

  // R6: read strobe is a single-cycle pulse
  p_rd_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  // R7: drivers only with output enable high now and in the previous cycle
  p_drive_safe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (oe_n && $past(oe_n) && !we_n));

  // R7: write enable low only inside a column pulse with drivers on
  p_write_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!cas_n && !ras_n && dq_oe));

  // R8: output enable low only for reads inside an open row
  p_oe_read_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (we_n && !ras_n));

  // R9: refresh order, column strobe low before the row strobe falls
  p_cbr_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n) |-> $past(!cas_n));

  // R11: one request at a time
  p_one_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

endmodule

bind edo_page_ctrl edo_page_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rd_valid  (rd_valid),
  .ras_n     (dram_ras_n),
  .cas_n     (dram_cas_n),
  .we_n      (dram_we_n),
  .oe_n      (dram_oe_n),
  .dq_oe     (dram_dq_oe)
);

// File: tb/tb_edo_page_ctrl.sv
module tb_edo_page_ctrl;

  localparam int ROW_W = 11;
  localparam int COL_W = 11;
  localparam int AW    = ROW_W + COL_W;
  localparam int RCD   = 2;
  localparam int CASW  = 2;
  localparam int CP    = 2;
  localparam int RP    = 3;
  localparam int CSR   = 1;
  localparam int REFR  = 3;
  localparam int IDLE  = 6;
  localparam int REFI  = 500;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic          req_write;
  logic [AW-1:0] req_addr;
  logic [3:0]    req_wdata;
  logic          rd_valid;
  logic [3:0]    rd_data;
  logic [10:0]   dram_addr;
  logic          ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [3:0]    dq_out;
  logic [3:0]    dq_in;

  edo_page_ctrl #(
    .ROW_W (ROW_W), .COL_W (COL_W), .DQ_W (4),
    .RCD_CYC (RCD), .CAS_CYC (CASW), .CP_CYC (CP), .RP_CYC (RP),
    .CSR_CYC (CSR), .REFR_CYC (REFR), .IDLE_CYC (IDLE), .REF_INTERVAL (REFI)
  ) dut (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
    .req_addr (req_addr), .req_wdata (req_wdata),
    .rd_valid (rd_valid), .rd_data (rd_data),
    .dram_addr (dram_addr), .dram_ras_n (ras_n), .dram_cas_n (cas_n),
    .dram_we_n (we_n), .dram_oe_n (oe_n),
    .dram_dq_out (dq_out), .dram_dq_oe (dq_oe), .dram_dq_in (dq_in)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference state: device contents, host shadow, read order
  logic [3:0] mem    [int];
  logic [3:0] shadow [int];
  logic [3:0] rdq    [$];

  function automatic logic [3:0] dflt(input int key);
    return 4'(key) ^ 4'(key >> 11) ^ 4'h9;
  endfunction

  logic [10:0] exp_row, exp_col;

  // behavioural device and pin monitor, one pass per cycle
  bit   prev_ras = 1, prev_cas = 1, prev_oe = 1;
  int   ras_hi_run = 100, ras_lo_run = 0, cas_lo_run = 0, cas_hi_run = 0, open_run = 0;
  int   last_open_run = -1, rise_cnt = 0, acts = 0, refs = 0;
  int   cyc = 0, last_ref = -1;
  bit   in_ref = 0, first_cas = 0, drv_valid = 0;
  logic [10:0] m_row, m_col;
  logic [3:0]  drv_data;

  initial dq_in = 'z;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (!prev_cas && cas_n && !in_ref)
        chk(cas_lo_run == CASW, "R3", "column pulse width", cas_lo_run, CASW);
      if (prev_ras && !ras_n) begin
        chk(ras_hi_run >= RP, "R5", "row strobe precharge", ras_hi_run, RP);
        if (!cas_n) begin
          refs++;
          in_ref = 1;
          chk(!prev_cas, "R9", "column before row at refresh", prev_cas, 0);
          if (last_ref >= 0)
            chk((cyc - last_ref >= REFI) && (cyc - last_ref <= REFI + 24), "R9",
                "refresh spacing", cyc - last_ref, REFI);
          last_ref = cyc;
        end else begin
          acts++;
          m_row = dram_addr;
          first_cas = 1;
          ras_lo_run = 0;
          chk(dram_addr == exp_row, "R2", "row field on bus", dram_addr, exp_row);
        end
      end
      if (!prev_ras && ras_n) begin
        last_open_run = open_run;
        rise_cnt++;
        in_ref = 0;
      end
      if (!ras_n && !in_ref && prev_cas && !cas_n) begin
        m_col = dram_addr;
        chk(dram_addr == exp_col, "R2", "column field on bus", dram_addr, exp_col);
        if (first_cas)
          chk(ras_lo_run == RCD, "R2", "row to column delay", ras_lo_run, RCD);
        else
          chk(cas_hi_run >= CP, "R3", "column precharge", cas_hi_run, CP);
        first_cas = 0;
        if (!we_n) begin
          chk(oe_n && dq_oe, "R7", "write strobes", {oe_n, dq_oe}, 2'b11);
          if (oe_n) mem[int'({m_row, m_col})] = dq_out;
        end else begin
          chk(!oe_n, "R8", "output enable at read column", oe_n, 0);
          drv_data  = mem.exists(int'({m_row, m_col})) ? mem[int'({m_row, m_col})]
                                                        : dflt(int'({m_row, m_col}));
          drv_valid = 1;
        end
      end
      if (dq_oe)
        chk(oe_n && prev_oe, "R7", "drive with output enable high", {prev_oe, oe_n}, 2'b11);
      if (!oe_n)
        chk(we_n && !ras_n, "R8", "output enable only in read", {we_n, ras_n}, 2'b10);
      if (rd_valid) begin
        if (rdq.size() == 0) begin
          chk(0, "R6", "unexpected read pulse", rd_data, 0);
        end else begin
          automatic logic [3:0] e = rdq.pop_front();
          chk(rd_data == e, "R6", "read data", rd_data, e);
        end
      end
      ras_hi_run = ras_n ? ras_hi_run + 1 : 0;
      if (!ras_n) ras_lo_run++;
      cas_lo_run = !cas_n ? cas_lo_run + 1 : 0;
      cas_hi_run = cas_n ? cas_hi_run + 1 : 0;
      open_run   = (!ras_n && cas_n) ? open_run + 1 : 0;
      if (ras_n || oe_n) drv_valid = 0;
      dq_in = (drv_valid && !oe_n) ? drv_data : 4'bz;
      prev_ras = ras_n;
      prev_cas = cas_n;
      prev_oe  = oe_n;
    end
  end

  task automatic host(input bit wr, input logic [AW-1:0] a, input logic [3:0] d);
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    exp_row = a[AW-1:COL_W];
    exp_col = a[COL_W-1:0];
    if (wr) begin
      shadow[int'(a)] = d;
    end else begin
      rdq.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : dflt(int'(a)));
    end
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R11", "ready low after acceptance", req_ready, 0);
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && rdq.size() != 0; i++) @(negedge clk);
    chk(rdq.size() == 0, "R6", "all reads returned", rdq.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_write = 1'b0;
    req_addr = '0;
    req_wdata = '0;
    exp_row = '0;
    exp_col = '0;
    repeat (4) @(negedge clk);
    // R1: reset values at the pins
    chk(ras_n && cas_n, "R1", "strobes high in reset", {ras_n, cas_n}, 2'b11);
    chk(we_n && oe_n, "R1", "enables high in reset", {we_n, oe_n}, 2'b11);
    chk(!dq_oe && !rd_valid, "R1", "drivers and read pulse off", {dq_oe, rd_valid}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(req_ready, "R11", "ready once out of reset", req_ready, 1);

    // R10: idle close after a single read
    begin
      automatic int r0 = rise_cnt;
      host(0, {11'd5, 11'd3}, 4'h0);
      for (int i = 0; i < 60 && rise_cnt == r0; i++) @(negedge clk);
      chk(last_open_run == CP + IDLE, "R10", "idle close window", last_open_run, CP + IDLE);
      drain();
    end

    // R4: writes then reads within one row use a single activation
    begin
      automatic int a0 = acts;
      for (int c = 0; c < 4; c++) host(1, {11'd7, 11'(c)}, 4'(4'hA + c));
      for (int c = 0; c < 4; c++) host(0, {11'd7, 11'(c)}, 4'h0);
      drain();
      chk(acts - a0 == 1, "R4", "activations for a page of hits", acts - a0, 1);
    end

    // R5: alternating rows each reopen with a full precharge
    begin
      automatic int a0 = acts;
      host(0, {11'd9, 11'd1}, 4'h0);
      host(0, {11'd10, 11'd1}, 4'h0);
      host(1, {11'd9, 11'd1}, 4'h6);
      host(0, {11'd9, 11'd1}, 4'h0);
      drain();
      chk(acts - a0 == 3, "R5", "activations for row misses", acts - a0, 3);
    end

    // mixed traffic across rows including the top row and top column
    for (int n = 0; n < 70; n++) begin
      automatic int rs = $urandom_range(0, 2);
      automatic logic [10:0] r = (rs == 0) ? 11'd3 : (rs == 1) ? 11'd4 : 11'h7FF;
      automatic logic [10:0] c = ($urandom_range(0, 7) == 0) ? 11'h7FF : 11'($urandom_range(0, 15));
      host(1'($urandom_range(0, 1)), {r, c}, 4'($urandom));
    end
    drain();

    // R9: refresh keeps running with the host quiet
    begin
      automatic int f0 = refs;
      repeat (2 * REFI + 60) @(negedge clk);
      chk(refs - f0 >= 2, "R9", "refresh count while idle", refs - f0, 2);
      chk(refs >= 3, "R9", "refreshes since reset", refs, 3);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule